// File: doc/BRIEF.md
# Parallel-Bus Reader for an Eight-Channel Simultaneous-Sampling ADC

This block runs a 16-bit successive-approximation converter that samples eight inputs at the same instant and returns the results over a 16-bit parallel bus. After a power-up reset pulse, an internal rate timer starts each conversion. A single start line drives both of the converter's start inputs. The block then waits for the busy handshake to rise and fall. While chip select stays low, it reads the eight channel words one after another. Each word leaves the block with a one-cycle valid strobe and its 3-bit channel index.

The requested oversampling code is clamped to a legal value. It is applied at each conversion start and held for the whole frame. The same code stretches the rate timer, so conversions never come faster than the selected ratio allows.

The block checks the first-data flag on the first read of each frame. If the flag is missing, the block drops the frame. If busy does not complete within a bounded wait, the block abandons the frame. Each fault is reported on its own one-cycle pulse.

Top module: `sadc_par_reader`

## Requirements
- R1: After `rst` is released, `adc_reset` stays high for exactly `RST_CYCLES` clocks. While it is high, `adc_convst`, `adc_cs_n` and `adc_rd_n` stay high and `smp_valid` stays low.
- R2: Each conversion start drives `adc_convst` low for exactly `CONV_LOW` consecutive clocks.
- R3: At each conversion start, `adc_os` takes the value of `os_req`, except that code 7 is replaced by 6. `adc_os` never shows 3'b111 and changes only in the clock where a start pulse begins.
- R4: Two consecutive start pulses begin at least `BASE_PERIOD << c` clocks apart, where c is the `adc_os` code applied at the earlier start (code 0 means ratio 1, and each step doubles the ratio).
- R5: `adc_rd_n` goes low only after `adc_busy` has risen and fallen following the latest start pulse, and never while `adc_busy` is high.
- R6: A frame with no fault produces eight read strobes. Each strobe is low for `RD_LOW` clocks, and consecutive strobes are separated by `RD_HIGH` high clocks. `adc_cs_n` stays low across the burst, and `adc_rd_n` is never low while `adc_cs_n` is high.
- R7: The word on `adc_db` in the last low clock of each strobe is presented on `smp_data` in the following clock, with `smp_valid` high for one clock. `smp_chan` counts 0 to 7 in read order.
- R8: If `adc_first` is low in the last low clock of the first strobe of a frame, `err_align` pulses high for one clock, no `smp_valid` is produced for that frame, and the burst stops after that strobe.
- R9: If `adc_busy` has not risen and then fallen within `BUSY_TIMEOUT` clocks after the start pulse ends, `err_timeout` pulses high for one clock. No read strobe occurs in that frame, and the next conversion is still started by the rate timer.
- R10: The 16-bit two's complement words pass through unchanged, including 16'h8000, 16'h7FFF, 16'h0000 and 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| os_req | input | 3 | Requested oversampling code (ratio 2^code) |
| adc_busy | input | 1 | Converter busy, high during conversion |
| adc_first | input | 1 | High while the channel-0 word is on the bus |
| adc_db | input | 16 | Parallel data bus from the converter |
| adc_convst | output | 1 | Shared conversion start, active low pulse |
| adc_reset | output | 1 | Converter reset, active high |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_os | output | 3 | Applied oversampling code |
| smp_valid | output | 1 | One-clock strobe for each channel word |
| smp_chan | output | 3 | Channel index of the presented word |
| smp_data | output | 16 | Channel word, two's complement |
| err_timeout | output | 1 | One-clock pulse when the busy handshake does not complete |
| err_align | output | 1 | One-clock pulse when first-data is missing on the first read |

## Verification
The properties assume that `adc_busy`, `adc_first` and `adc_db` are already synchronous to `clk`. They also assume that the converter never raises busy on its own, and that busy is low again before the next start pulse, so that no read ever overlaps a busy period. The bench models the converter on the falling clock edge. Its busy rises only after the start pulse ends, and every frame that holds busy past the timeout is given a long oversampling period, so the next start always finds busy low. Random oversampling codes and fault frames are mixed with directed frames carrying the extreme two's complement words and the illegal code 7.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int DATA_W = 16;
    localparam int NUM_CH = 8;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int OS_W   = 3;

    localparam logic [OS_W-1:0] OS_TOP   = 3'd6;
    localparam logic [OS_W-1:0] OS_ILLEG = 3'd7;

    typedef enum logic [2:0] {
        ST_RST,
        ST_IDLE,
        ST_CONV,
        ST_WAIT_HI,
        ST_WAIT_LO,
        ST_RD_LO,
        ST_RD_HI
    } seq_state_e;

    typedef struct packed {
        logic [CH_W-1:0]   chan;
        logic [DATA_W-1:0] data;
    } chan_word_t;

    function automatic logic [OS_W-1:0] os_legal(input logic [OS_W-1:0] code);
        return (code == OS_ILLEG) ? OS_TOP : code;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sadc_rate_timer.sv
module sadc_rate_timer
    import sadc_pkg::*;
#(
    parameter int BASE_PERIOD = 250
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [OS_W-1:0] os_code,
    output logic            expired
);
    localparam int TMR_W = $clog2(BASE_PERIOD * 64 + 1);

    logic [TMR_W-1:0] remain;
    logic [TMR_W-1:0] period;

    assign period  = TMR_W'(BASE_PERIOD) << os_code;
    assign expired = (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= period - TMR_W'(1);
        end else if (remain != '0) begin
            remain <= remain - TMR_W'(1);
        end
    end
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
    import sadc_pkg::*;
#(
    parameter int RST_CYCLES   = 8,
    parameter int CONV_LOW     = 2,
    parameter int RD_LOW       = 2,
    parameter int RD_HIGH      = 1,
    parameter int BUSY_TIMEOUT = 400
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic [OS_W-1:0] os_next,
    input  logic            busy,
    input  logic            first,
    output logic            start,
    output logic            convst,
    output logic            areset,
    output logic            cs_n,
    output logic            rd_n,
    output logic [OS_W-1:0] os_q,
    output logic            cap_en,
    output logic [CH_W-1:0] cap_chan,
    output logic            err_t,
    output logic            err_a
);
    localparam int MAXD = max_of(max_of(RST_CYCLES, CONV_LOW),
                                 max_of(max_of(RD_LOW, RD_HIGH), BUSY_TIMEOUT));
    localparam int CW   = $clog2(MAXD + 1);

    seq_state_e      state;
    logic [CW-1:0]   cnt;
    logic [CH_W-1:0] ch;
    logic            rd_last;
    logic            misalign;

    assign start    = (state == ST_IDLE) && tick;
    assign convst   = (state != ST_CONV);
    assign areset   = (state == ST_RST);
    assign cs_n     = !((state == ST_RD_LO) || (state == ST_RD_HI));
    assign rd_n     = (state != ST_RD_LO);
    assign rd_last  = (state == ST_RD_LO) && (cnt == CW'(RD_LOW - 1));
    assign misalign = (ch == '0) && !first;
    assign cap_en   = rd_last && !misalign;
    assign cap_chan = ch;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RST;
            cnt   <= '0;
            ch    <= '0;
            os_q  <= '0;
            err_t <= 1'b0;
            err_a <= 1'b0;
        end else begin
            err_t <= 1'b0;
            err_a <= 1'b0;
            case (state)
                ST_RST: begin
                    if (cnt == CW'(RST_CYCLES - 1)) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_IDLE: begin
                    if (tick) begin
                        state <= ST_CONV;
                        os_q  <= os_next;
                        cnt   <= '0;
                    end
                end
                ST_CONV: begin
                    if (cnt == CW'(CONV_LOW - 1)) begin
                        state <= ST_WAIT_HI;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_WAIT_HI: begin
                    if (busy) begin
                        state <= ST_WAIT_LO;
                        cnt   <= cnt + CW'(1);
                    end else if (cnt == CW'(BUSY_TIMEOUT - 1)) begin
                        state <= ST_IDLE;
                        err_t <= 1'b1;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_WAIT_LO: begin
                    if (!busy) begin
                        state <= ST_RD_LO;
                        cnt   <= '0;
                        ch    <= '0;
                    end else if (cnt >= CW'(BUSY_TIMEOUT - 1)) begin
                        state <= ST_IDLE;
                        err_t <= 1'b1;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_RD_LO: begin
                    if (rd_last) begin
                        cnt <= '0;
                        if (misalign) begin
                            state <= ST_IDLE;
                            err_a <= 1'b1;
                        end else begin
                            state <= ST_RD_HI;
                        end
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_RD_HI: begin
                    if (cnt == CW'(RD_HIGH - 1)) begin
                        cnt <= '0;
                        if (ch == CH_W'(NUM_CH - 1)) begin
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_RD_LO;
                            ch    <= ch + CH_W'(1);
                        end
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture
    import sadc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [CH_W-1:0]   cap_chan,
    input  logic [DATA_W-1:0] db,
    output logic              valid,
    output chan_word_t        word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            word  <= '0;
        end else begin
            valid <= cap_en;
            if (cap_en) begin
                word.chan <= cap_chan;
                word.data <= db;
            end
        end
    end
endmodule

// File: rtl/sadc_par_reader.sv
module sadc_par_reader
    import sadc_pkg::*;
#(
    parameter int BASE_PERIOD  = 250,
    parameter int RST_CYCLES   = 8,
    parameter int CONV_LOW     = 2,
    parameter int RD_LOW       = 2,
    parameter int RD_HIGH      = 1,
    parameter int BUSY_TIMEOUT = 400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        os_req,
    input  logic              adc_busy,
    input  logic              adc_first,
    input  logic [15:0]       adc_db,
    output logic              adc_convst,
    output logic              adc_reset,
    output logic              adc_cs_n,
    output logic              adc_rd_n,
    output logic [2:0]        adc_os,
    output logic              smp_valid,
    output logic [2:0]        smp_chan,
    output logic [15:0]       smp_data,
    output logic              err_timeout,
    output logic              err_align
);
    logic            tick;
    logic            start;
    logic            cap_en;
    logic [CH_W-1:0] cap_chan;
    logic [OS_W-1:0] os_next;
    chan_word_t      word;

    assign os_next = os_legal(os_req);

    sadc_rate_timer #(
        .BASE_PERIOD(BASE_PERIOD)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .load    (start),
        .os_code (os_next),
        .expired (tick)
    );

    sadc_seq #(
        .RST_CYCLES   (RST_CYCLES),
        .CONV_LOW     (CONV_LOW),
        .RD_LOW       (RD_LOW),
        .RD_HIGH      (RD_HIGH),
        .BUSY_TIMEOUT (BUSY_TIMEOUT)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .os_next  (os_next),
        .busy     (adc_busy),
        .first    (adc_first),
        .start    (start),
        .convst   (adc_convst),
        .areset   (adc_reset),
        .cs_n     (adc_cs_n),
        .rd_n     (adc_rd_n),
        .os_q     (adc_os),
        .cap_en   (cap_en),
        .cap_chan (cap_chan),
        .err_t    (err_timeout),
        .err_a    (err_align)
    );

    sadc_capture cap_i (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .cap_chan (cap_chan),
        .db       (adc_db),
        .valid    (smp_valid),
        .word     (word)
    );

    assign smp_chan = word.chan;
    assign smp_data = word.data;
endmodule

// File: rtl/sadc_par_reader_chk.sv
module sadc_par_reader_chk #(
    parameter int BASE_PERIOD = 250
) (
    input logic       clk,
    input logic       rst,
    input logic       adc_busy,
    input logic       adc_convst,
    input logic       adc_reset,
    input logic       adc_cs_n,
    input logic       adc_rd_n,
    input logic [2:0] adc_os,
    input logic       smp_valid,
    input logic       err_timeout,
    input logic       err_align
);
    logic        cv_q;
    logic        seen;
    logic [31:0] gap;
    logic [31:0] need;
    logic        fall;

    assign fall = cv_q && !adc_convst;

    always_ff @(posedge clk) begin
        if (rst) begin
            cv_q <= 1'b1;
            seen <= 1'b0;
            gap  <= '0;
            need <= '0;
        end else begin
            cv_q <= adc_convst;
            if (fall) begin
                seen <= 1'b1;
                gap  <= 32'd1;
                need <= 32'(BASE_PERIOD) << adc_os;
            end else if (gap != 32'hFFFF_FFFF) begin
                gap <= gap + 32'd1;
            end
        end
    end

    // R1
    a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (rst)
        adc_reset |-> (adc_convst && adc_cs_n && adc_rd_n && !smp_valid));

    // R3
    a_r3_os_legal: assert property (@(posedge clk) disable iff (rst)
        adc_os != 3'b111);

    // R3
    a_r3_os_changes_at_start: assert property (@(posedge clk) disable iff (rst)
        !$stable(adc_os) |-> $fell(adc_convst));

    // R4
    a_r4_rate_limit: assert property (@(posedge clk) disable iff (rst)
        (fall && seen) |-> (gap >= need));

    // R5
    a_r5_no_read_while_busy: assert property (@(posedge clk) disable iff (rst)
        !adc_rd_n |-> !adc_busy);

    // R6
    a_r6_read_inside_select: assert property (@(posedge clk) disable iff (rst)
        !adc_rd_n |-> !adc_cs_n);

    // R8
    a_r8_align_drops_word: assert property (@(posedge clk) disable iff (rst)
        err_align |-> !smp_valid);

    // R9
    a_r9_timeout_no_bus: assert property (@(posedge clk) disable iff (rst)
        err_timeout |-> (adc_cs_n && adc_rd_n));
endmodule

bind sadc_par_reader sadc_par_reader_chk #(
    .BASE_PERIOD(BASE_PERIOD)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .adc_busy    (adc_busy),
    .adc_convst  (adc_convst),
    .adc_reset   (adc_reset),
    .adc_cs_n    (adc_cs_n),
    .adc_rd_n    (adc_rd_n),
    .adc_os      (adc_os),
    .smp_valid   (smp_valid),
    .err_timeout (err_timeout),
    .err_align   (err_align)
);

// File: tb/sadc_par_reader_tb_top.sv
module sadc_par_reader_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 40;
    localparam int RSTC       = 5;
    localparam int CONVL      = 2;
    localparam int RDL        = 2;
    localparam int RDH        = 1;
    localparam int TMO        = 32;
    localparam int BUSY_LEN   = 10;
    localparam int NF         = 30;

    localparam int M_NORM  = 0;
    localparam int M_MIS   = 1;
    localparam int M_NONE  = 2;
    localparam int M_STUCK = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  os_req = 3'd0;
    logic        adc_busy = 1'b0;
    logic        adc_first = 1'b0;
    logic [15:0] adc_db = 16'h0;
    logic        adc_convst, adc_reset, adc_cs_n, adc_rd_n;
    logic [2:0]  adc_os;
    logic        smp_valid;
    logic [2:0]  smp_chan;
    logic [15:0] smp_data;
    logic        err_timeout, err_align;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sadc_par_reader #(
        .BASE_PERIOD  (BASE),
        .RST_CYCLES   (RSTC),
        .CONV_LOW     (CONVL),
        .RD_LOW       (RDL),
        .RD_HIGH      (RDH),
        .BUSY_TIMEOUT (TMO)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .os_req      (os_req),
        .adc_busy    (adc_busy),
        .adc_first   (adc_first),
        .adc_db      (adc_db),
        .adc_convst  (adc_convst),
        .adc_reset   (adc_reset),
        .adc_cs_n    (adc_cs_n),
        .adc_rd_n    (adc_rd_n),
        .adc_os      (adc_os),
        .smp_valid   (smp_valid),
        .smp_chan    (smp_chan),
        .smp_data    (smp_data),
        .err_timeout (err_timeout),
        .err_align   (err_align)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    function automatic int exp_os(input logic [2:0] c);
        return (c == 3'd7) ? 6 : int'(c);
    endfunction

    // converter model and monitor state
    logic [15:0] words [8];
    int  next_mode = M_NORM;
    int  cur_mode  = M_NORM;
    int  cyc = 0, prev_cyc = 0, prev_per = 0, nstarts = 0;
    int  rst_hi = 0, cv_low = 0, rd_low = 0, rd_hi = 0;
    int  nvalid = 0, nread = 0, nea = 0, net = 0;
    int  bcnt = 0, idx = 0;
    bit  busy_fell = 0, cv_prev = 1, rd_prev = 1, started;
    event conv_ev;

    task automatic close_frame();
        if (cur_mode == M_NORM) begin
            check(nvalid == 8, "R7 words per frame", nvalid, 8);
            check(nread == 8, "R6 strobes per frame", nread, 8);
            check(nea + net == 0, "R8/R9 no fault on good frame", nea + net, 0);
        end else if (cur_mode == M_MIS) begin
            check(nea == 1, "R8 align pulse", nea, 1);
            check(nvalid == 0, "R8 frame dropped", nvalid, 0);
            check(nread == 1, "R8 burst stops", nread, 1);
        end else begin
            check(net == 1, "R9 timeout pulse", net, 1);
            check(nvalid == 0, "R9 no words", nvalid, 0);
            check(nread == 0, "R9 no strobes", nread, 0);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        started = 0;
        if (rst) begin
            adc_busy = 0; idx = 0; bcnt = 0; rst_hi = 0;
            cv_prev = 1; rd_prev = 1; busy_fell = 0;
        end else begin
            if (adc_reset) rst_hi++;
            // start pulse begins
            if (cv_prev && !adc_convst) begin
                started = 1;
                if (nstarts == 0) begin
                    check(rst_hi == RSTC, "R1 reset length", rst_hi, RSTC);
                end else begin
                    close_frame();
                    check(cyc - prev_cyc >= prev_per, "R4 start spacing", cyc - prev_cyc, prev_per);
                end
                check(int'(adc_os) == exp_os(os_req), "R3 applied code", adc_os, exp_os(os_req));
                prev_cyc = cyc;
                prev_per = BASE << adc_os;
                nstarts++;
                cur_mode = next_mode;
                for (int i = 0; i < 8; i++) words[i] = 16'($urandom);
                if (nstarts == 1) begin
                    words[0] = 16'h8000; words[1] = 16'h7FFF;
                    words[2] = 16'h0000; words[3] = 16'hFFFF;
                end
                nvalid = 0; nread = 0; nea = 0; net = 0;
                busy_fell = 0; cv_low = 1;
            end else if (!adc_convst) begin
                cv_low++;
            end
            // start pulse ends: model begins conversion
            if (!cv_prev && adc_convst) begin
                check(cv_low == CONVL, "R2 start low time", cv_low, CONVL);
                if (cur_mode != M_NONE) begin
                    adc_busy = 1;
                    bcnt = (cur_mode == M_STUCK) ? TMO + 20 : BUSY_LEN;
                end
            end else if (adc_busy) begin
                bcnt--;
                if (bcnt == 0) begin
                    adc_busy = 0;
                    busy_fell = 1;
                    idx = (cur_mode == M_MIS) ? 1 : 0;
                end
            end
            // read strobes
            if (rd_prev && !adc_rd_n) begin
                if (nread > 0) check(rd_hi == RDH, "R6 strobe high time", rd_hi, RDH);
                check(busy_fell && !adc_busy, "R5 read after busy", busy_fell, 1);
                rd_low = 1;
            end else if (!adc_rd_n) begin
                rd_low++;
            end
            if (!rd_prev && adc_rd_n) begin
                check(rd_low == RDL, "R6 strobe low time", rd_low, RDL);
                nread++;
                idx++;
                rd_hi = 1;
            end else if (adc_rd_n && !adc_cs_n) begin
                rd_hi++;
            end
            if (smp_valid) begin
                if (nvalid < 8) begin
                    check(int'(smp_chan) == nvalid, "R7 channel order", smp_chan, nvalid);
                    check(smp_data == words[nvalid], "R7/R10 word value", smp_data, words[nvalid]);
                end else begin
                    check(0, "R7 extra word", nvalid, 7);
                end
                nvalid++;
            end
            if (err_align) nea++;
            if (err_timeout) net++;
            adc_db    = words[idx & 7];
            adc_first = (idx == 0);
        end
        cv_prev = adc_convst;
        rd_prev = adc_rd_n;
        if (started) ->conv_ev;
    end

    initial begin
        void'($urandom(32'h5EED_0A11));
        repeat (4) @(negedge clk);
        // R1 reset state
        check(adc_reset == 1, "R1 reset asserted", adc_reset, 1);
        check(adc_convst == 1 && adc_cs_n == 1 && adc_rd_n == 1, "R1 lines idle",
              {adc_convst, adc_cs_n, adc_rd_n}, 7);
        check(smp_valid == 0 && err_align == 0 && err_timeout == 0, "R1 no output",
              {smp_valid, err_align, err_timeout}, 0);
        @(posedge clk);
        rst <= 1'b0;
        for (int f = 0; f < NF; f++) begin
            @(conv_ev);
            next_mode = M_NORM;
            if (f == 2) begin
                next_mode = M_MIS; os_req = 3'd1;
            end else if (f == 4) begin
                next_mode = M_NONE; os_req = 3'd0;
            end else if (f == 6) begin
                next_mode = M_STUCK; os_req = 3'd2;
            end else if (f == 8) begin
                os_req = 3'd7;
            end else if (f == 10) begin
                os_req = 3'd6;
            end else begin
                os_req = 3'($urandom_range(0, 3));
                if ($urandom_range(0, 9) == 0) next_mode = M_MIS;
            end
        end
        @(conv_ev);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", nstarts, NF + 1);
        finish_run();
    end

endmodule